// File: doc/BRIEF.md
# Masked Accelerator Control Front End

This block sits between a processor's special-register accesses and a family of masked arithmetic accelerators. Software loads two operands, each split into two Boolean or arithmetic shares and viewed as eight 32-bit lanes. It then writes a control word that holds an operation code and a start bit. Software polls a status word with two bits. BUSY shows that an operation is running. READY shows that the operand registers may be overwritten. When BUSY falls, software reads two result shares.

The block checks every access against its current state. A control write while busy is refused, and so is a control write carrying an unknown operation code. An operand write while not ready is also refused. Each refused access raises a one-cycle software-error pulse and changes nothing else. Once started, the block feeds the selected accelerator one lane per valid/ready handshake, lowest lane first. It collects one response per lane, in lane order, through a valid-only return path whose latency is not fixed. Each response lands directly in its lane of the result registers. Old results therefore remain readable until the first lane of the next operation comes back.

Top module: `masked_accel_front`

## Requirements
- R1: After reset the status word reads 0x2 (bit 0 BUSY = 0, bit 1 READY = 1), the control readback reads 0, both result shares read 0 and `swErr` is low.
- R2: A control write uses bit 0 as start and bits 5:1 as the operation code. Only codes 11, 12, 16 and 23 are legal. An accepted write stores the code, and the control readback then shows it in bits 5:1 with every other bit 0. Control bits 31:6 are ignored and raise no error.
- R3: A control write with an illegal code raises `swErr` for exactly one cycle, starting the cycle after the write. It leaves the stored code unchanged and starts nothing.
- R4: Any control write while BUSY is 1 raises `swErr` the cycle after and is otherwise ignored. This holds whether or not start is set. The stored code and the running operation are unchanged.
- R5: An operand write (select 0 = operand A share 0, 1 = A share 1, 2 = B share 0, 3 = B share 1) while READY is 0 raises `swErr` the cycle after and leaves the operand register unchanged.
- R6: An accepted start makes BUSY 1 and READY 0 in the cycle after the write. Lanes go out lowest first, one per cycle in which `accReqValid` and `accReqReady` are both high. READY returns to 1 the cycle after the last lane is accepted, which is 8 cycles after the start write when the accelerator is always ready.
- R7: The response that arrives k-th (k = 0..7) is written into bits 32k+31:32k of each result share. BUSY falls the cycle after the eighth response is taken, and the request carries the stored code on `accReqOp`.
- R8: Result registers do not change while BUSY is 0. After a new start they keep their old value until the first response of the new operation, which replaces lane 0 only.
- R9: Operand writes while BUSY is 1 but READY is 1 are accepted without error and do not disturb the running operation.
- R10: Status bits 31:2 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 32 | Control word: bit 0 start, bits 5:1 operation code |
| ctlRdData | output | 32 | Control readback: stored code in bits 5:1 |
| statusRd | output | 32 | Status: bit 0 BUSY, bit 1 READY |
| opndWrEn | input | 1 | Operand write strobe |
| opndWrSel | input | 2 | Operand register select |
| opndWrData | input | 256 | Operand write data, eight 32-bit lanes |
| resShare0 | output | 256 | Result share 0 |
| resShare1 | output | 256 | Result share 1 |
| swErr | output | 1 | One-cycle software error pulse |
| accReqValid | output | 1 | Lane request valid |
| accReqReady | input | 1 | Accelerator accepts lane |
| accReqOp | output | 5 | Operation code for the accelerator |
| accReqA0 | output | 32 | Current lane of operand A share 0 |
| accReqA1 | output | 32 | Current lane of operand A share 1 |
| accReqB0 | output | 32 | Current lane of operand B share 0 |
| accReqB1 | output | 32 | Current lane of operand B share 1 |
| accRspValid | input | 1 | Result lane valid |
| accRsp0 | input | 32 | Result lane, share 0 |
| accRsp1 | input | 32 | Result lane, share 1 |

## Verification
All state sits in registers, so every result of a write is due exactly one clock after the edge that takes it. This covers the error pulse, the stored code, BUSY rising and READY falling, and the checks sample one step past that edge. With an always-ready accelerator of response latency L, READY is due 8 cycles after the start edge and BUSY falls at 8 + L. Result lane 0 changes at 1 + L. The bench counts clock edges from the start edge and compares each count to these figures, and it also samples the results one cycle before the first new lane is due.

// File: rtl/maf_pkg.sv
package maf_pkg;

  localparam int OP_W      = 5;
  localparam int START_BIT = 0;
  localparam int OP_LSB    = 1;
  localparam int NUM_OPND  = 4;

  localparam logic [OP_W-1:0] OP_ARITH_TO_BOOL = 5'd11;
  localparam logic [OP_W-1:0] OP_BOOL_TO_ARITH = 5'd16;
  localparam logic [OP_W-1:0] OP_SEC_ADD       = 5'd23;
  localparam logic [OP_W-1:0] OP_SEC_ADD_MOD   = 5'd12;

  typedef struct packed {
    logic       cfgWe;
    logic       opndWe;
    logic [1:0] opndSel;
    logic       resWe;
  } strobes_t;

  function automatic logic isLegalOp(input logic [OP_W-1:0] code);
    return (code == OP_ARITH_TO_BOOL) || (code == OP_BOOL_TO_ARITH) ||
           (code == OP_SEC_ADD) || (code == OP_SEC_ADD_MOD);
  endfunction

endpackage

// File: rtl/maf_ctrl.sv
module maf_ctrl
  import maf_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWrEn,
  input  logic                  ctlStart,
  input  logic [OP_W-1:0]       ctlOp,
  input  logic                  opndWrEn,
  input  logic [1:0]            opndWrSel,
  input  logic                  accReqReady,
  input  logic                  accRspValid,
  output strobes_t              strb,
  output logic [LIDX_W-1:0]     sendLane,
  output logic [LIDX_W-1:0]     recvLane,
  output logic                  accReqValid,
  output logic                  busy,
  output logic                  ready,
  output logic                  swErr
);

  localparam int IDX_W  = $clog2(LANES + 1);
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] FULL = IDX_W'(LANES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] sendCnt;
  logic [IDX_W-1:0] recvCnt;
  logic ctlBad, ctlOk, startGo, opndBad, reqFire, rspTake;

  always_comb begin
    ctlBad  = ctlWrEn && (busy || !isLegalOp(ctlOp));
    ctlOk   = ctlWrEn && !ctlBad;
    startGo = ctlOk && ctlStart;
    opndBad = opndWrEn && !ready;
    reqFire = accReqValid && accReqReady;
    rspTake = accRspValid && busy && (recvCnt != FULL);
  end

  assign ready       = !busy || (sendCnt == FULL);
  assign accReqValid = busy && (sendCnt != FULL);
  assign sendLane    = sendCnt[LIDX_W-1:0];
  assign recvLane    = recvCnt[LIDX_W-1:0];

  always_comb begin
    strb         = '0;
    strb.cfgWe   = ctlOk;
    strb.opndWe  = opndWrEn && ready;
    strb.opndSel = opndWrSel;
    strb.resWe   = rspTake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sendCnt <= '0;
      recvCnt <= '0;
      swErr   <= 1'b0;
    end else begin
      swErr <= ctlBad || opndBad;
      if (startGo) begin
        busy    <= 1'b1;
        sendCnt <= '0;
        recvCnt <= '0;
      end else begin
        if (reqFire) sendCnt <= sendCnt + 1'b1;
        if (rspTake) begin
          recvCnt <= recvCnt + 1'b1;
          if (recvCnt == LAST) busy <= 1'b0;
        end
      end
    end
  end

  // R3: a refused access never coincides with a launch
  a_r3_err_no_start: assert property (@(posedge clk) disable iff (!rstN)
    swErr |-> !$rose(busy));

  // R6: launch only from a control write, with READY dropped
  a_r6_start_ready_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!ready && $past(ctlWrEn)));

  // R7: operation ends only after every lane was sent
  a_r7_fall_all_sent: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sendCnt == FULL));

  // R7: never more responses than requests
  a_r7_recv_le_send: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (recvCnt <= sendCnt));

endmodule

// File: rtl/maf_datapath.sv
module maf_datapath
  import maf_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic [OP_W-1:0]            cfgOp,
  input  logic [LANE_W*LANES-1:0]    opndWrData,
  input  logic [LIDX_W-1:0]          sendLane,
  input  logic [LIDX_W-1:0]          recvLane,
  input  logic [LANE_W-1:0]          accRsp0,
  input  logic [LANE_W-1:0]          accRsp1,
  output logic [OP_W-1:0]            curOp,
  output logic [LANE_W-1:0]          accReqA0,
  output logic [LANE_W-1:0]          accReqA1,
  output logic [LANE_W-1:0]          accReqB0,
  output logic [LANE_W-1:0]          accReqB1,
  output logic [LANE_W*LANES-1:0]    resShare0,
  output logic [LANE_W*LANES-1:0]    resShare1
);

  localparam int WIDE_W = LANE_W * LANES;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WIDE_W-1:0] opndQ [NUM_OPND];
  int laneBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           curOp <= '0;
    else if (strb.cfgWe) curOp <= cfgOp;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : gOpnd
    logic [WIDE_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strb.opndWe && (strb.opndSel == 2'(g))) q <= opndWrData;
    end
    assign opndQ[g] = q;
  end

  always_comb begin
    laneBase = int'(sendLane) * LANE_W;
    accReqA0 = opndQ[0][laneBase +: LANE_W];
    accReqA1 = opndQ[1][laneBase +: LANE_W];
    accReqB0 = opndQ[2][laneBase +: LANE_W];
    accReqB1 = opndQ[3][laneBase +: LANE_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : gRes
    logic [LANE_W-1:0] q0, q1;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q0 <= '0;
        q1 <= '0;
      end else if (strb.resWe && (recvLane == LIDX_W'(l))) begin
        q0 <= accRsp0;
        q1 <= accRsp1;
      end
    end
    assign resShare0[l*LANE_W +: LANE_W] = q0;
    assign resShare1[l*LANE_W +: LANE_W] = q1;
  end

endmodule

// File: rtl/masked_accel_front.sv
module masked_accel_front
  import maf_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 8,
  parameter int CTL_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctlWrEn,
  input  logic [CTL_W-1:0]        ctlWrData,
  output logic [CTL_W-1:0]        ctlRdData,
  output logic [CTL_W-1:0]        statusRd,
  input  logic                    opndWrEn,
  input  logic [1:0]              opndWrSel,
  input  logic [LANE_W*LANES-1:0] opndWrData,
  output logic [LANE_W*LANES-1:0] resShare0,
  output logic [LANE_W*LANES-1:0] resShare1,
  output logic                    swErr,
  output logic                    accReqValid,
  input  logic                    accReqReady,
  output logic [OP_W-1:0]         accReqOp,
  output logic [LANE_W-1:0]       accReqA0,
  output logic [LANE_W-1:0]       accReqA1,
  output logic [LANE_W-1:0]       accReqB0,
  output logic [LANE_W-1:0]       accReqB1,
  input  logic                    accRspValid,
  input  logic [LANE_W-1:0]       accRsp0,
  input  logic [LANE_W-1:0]       accRsp1
);

  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CFG_HI = OP_LSB + OP_W;

  strobes_t          strb;
  logic [LIDX_W-1:0] sendLane, recvLane;
  logic [OP_W-1:0]   curOp;
  logic              busy, ready;
  logic              unusedCtlHi;

  assign unusedCtlHi = ^ctlWrData[CTL_W-1:CFG_HI];

  maf_ctrl #(.LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctlWrEn     (ctlWrEn),
    .ctlStart    (ctlWrData[START_BIT]),
    .ctlOp       (ctlWrData[OP_LSB +: OP_W]),
    .opndWrEn    (opndWrEn),
    .opndWrSel   (opndWrSel),
    .accReqReady (accReqReady),
    .accRspValid (accRspValid),
    .strb        (strb),
    .sendLane    (sendLane),
    .recvLane    (recvLane),
    .accReqValid (accReqValid),
    .busy        (busy),
    .ready       (ready),
    .swErr       (swErr)
  );

  maf_datapath #(.LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgOp      (ctlWrData[OP_LSB +: OP_W]),
    .opndWrData (opndWrData),
    .sendLane   (sendLane),
    .recvLane   (recvLane),
    .accRsp0    (accRsp0),
    .accRsp1    (accRsp1),
    .curOp      (curOp),
    .accReqA0   (accReqA0),
    .accReqA1   (accReqA1),
    .accReqB0   (accReqB0),
    .accReqB1   (accReqB1),
    .resShare0  (resShare0),
    .resShare1  (resShare1)
  );

  assign accReqOp  = curOp;
  assign ctlRdData = CTL_W'({curOp, 1'b0});
  assign statusRd  = CTL_W'({ready, busy});

  // R2: a running operation always carries a legal code
  a_r2_busy_op_legal: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> isLegalOp(curOp));

  // R4: control writes during an operation leave the stored code alone
  a_r4_busy_ctl_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && busy) |=> $stable(ctlRdData));

  // R8: results never move while idle
  a_r8_res_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(resShare0) && $stable(resShare1)));

endmodule

// File: tb/sim_masked_accel_front.sv
module sim_acc_stub #(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [4:0]  op,
  input  logic [31:0] a0,
  input  logic [31:0] a1,
  input  logic [31:0] b0,
  input  logic [31:0] b1,
  output logic        rspValid,
  output logic [31:0] rsp0,
  output logic [31:0] rsp1
);
  logic        vld [LAT];
  logic [31:0] d0  [LAT];
  logic [31:0] d1  [LAT];

  assign reqReady = 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LAT; k++) begin
        vld[k] <= 1'b0;
        d0[k]  <= '0;
        d1[k]  <= '0;
      end
    end else begin
      vld[0] <= reqValid;
      d0[0]  <= a0 + b0 + 32'(op);
      d1[0]  <= a1 ^ b1 ^ 32'(op);
      for (int k = 1; k < LAT; k++) begin
        vld[k] <= vld[k-1];
        d0[k]  <= d0[k-1];
        d1[k]  <= d1[k-1];
      end
    end
  end

  assign rspValid = vld[LAT-1];
  assign rsp0     = d0[LAT-1];
  assign rsp1     = d1[LAT-1];
endmodule

module sim_masked_accel_front;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctlWrEn = 1'b0;
  logic [31:0]  ctlWrData = '0;
  logic [31:0]  ctlRdData, statusRd;
  logic         opndWrEn = 1'b0;
  logic [1:0]   opndWrSel = '0;
  logic [255:0] opndWrData = '0;
  logic [255:0] resShare0, resShare1;
  logic         swErr, accReqValid, accReqReady, accRspValid;
  logic [4:0]   accReqOp;
  logic [31:0]  accReqA0, accReqA1, accReqB0, accReqB1, accRsp0, accRsp1;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  masked_accel_front u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .statusRd(statusRd), .opndWrEn(opndWrEn),
    .opndWrSel(opndWrSel), .opndWrData(opndWrData), .resShare0(resShare0),
    .resShare1(resShare1), .swErr(swErr), .accReqValid(accReqValid),
    .accReqReady(accReqReady), .accReqOp(accReqOp), .accReqA0(accReqA0),
    .accReqA1(accReqA1), .accReqB0(accReqB0), .accReqB1(accReqB1),
    .accRspValid(accRspValid), .accRsp0(accRsp0), .accRsp1(accRsp1)
  );

  sim_acc_stub #(.LAT(LAT)) u_stub (
    .clk(clk), .rstN(rstN), .reqValid(accReqValid), .reqReady(accReqReady),
    .op(accReqOp), .a0(accReqA0), .a1(accReqA1), .b0(accReqB0), .b1(accReqB1),
    .rspValid(accRspValid), .rsp0(accRsp0), .rsp1(accRsp1)
  );

  // {operation code, operand seed}
  localparam logic [36:0] VEC [4] = '{
    {5'd11, 32'h0000_1234},
    {5'd16, 32'hDEAD_0001},
    {5'd23, 32'h5A5A_7777},
    {5'd12, 32'hFFFF_FFF0}
  };

  function automatic logic [255:0] mkOpnd(input logic [31:0] seed);
    logic [255:0] v;
    for (int l = 0; l < 8; l++)
      v[l*32 +: 32] = (seed * 32'h9E37_79B1) ^ (32'(l) * 32'h0100_0193) ^ {seed[15:0], seed[31:16]};
    return v;
  endfunction

  function automatic logic [255:0] expSum(input logic [255:0] a, input logic [255:0] b, input logic [4:0] op);
    logic [255:0] v;
    for (int l = 0; l < 8; l++) v[l*32 +: 32] = a[l*32 +: 32] + b[l*32 +: 32] + 32'(op);
    return v;
  endfunction

  function automatic logic [255:0] expXor(input logic [255:0] a, input logic [255:0] b, input logic [4:0] op);
    logic [255:0] v;
    for (int l = 0; l < 8; l++) v[l*32 +: 32] = a[l*32 +: 32] ^ b[l*32 +: 32] ^ 32'(op);
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wrCtl(input logic start, input logic [4:0] op, input logic [25:0] hi);
    ctlWrEn = 1'b1;
    ctlWrData = {hi, op, start};
    tick();
    ctlWrEn = 1'b0;
    ctlWrData = '0;
  endtask

  task automatic wrOpnd(input logic [1:0] sel, input logic [255:0] data);
    opndWrEn = 1'b1;
    opndWrSel = sel;
    opndWrData = data;
    tick();
    opndWrEn = 1'b0;
  endtask

  task automatic loadAll(input logic [31:0] seed);
    for (int k = 0; k < 4; k++) wrOpnd(2'(k), mkOpnd(seed + 32'(k)));
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [255:0] a0, a1, b0, b1, e0, e1, old0, old1;
    int n;

    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 / R10 reset state
    chk("R1", "status", 256'(statusRd), 256'h2);
    chk("R1", "ctlRd", 256'(ctlRdData), 256'h0);
    chk("R1", "res0", resShare0, '0);
    chk("R1", "res1", resShare1, '0);
    chk("R1", "swErr", 256'(swErr), 256'h0);
    chk("R10", "status hi", 256'(statusRd[31:2]), 256'h0);

    // R2: legal code with junk in the upper bits, no start
    wrCtl(1'b0, 5'd16, 26'h3FF_FFFF);
    chk("R2", "no error", 256'(swErr), 256'h0);
    chk("R2", "readback", 256'(ctlRdData), 256'h20);
    chk("R2", "not started", 256'(statusRd), 256'h2);

    // R3: illegal codes
    wrCtl(1'b1, 5'd5, '0);
    chk("R3", "err pulse", 256'(swErr), 256'h1);
    chk("R3", "code kept", 256'(ctlRdData), 256'h20);
    chk("R3", "not started", 256'(statusRd), 256'h2);
    tick();
    chk("R3", "pulse one cycle", 256'(swErr), 256'h0);
    wrCtl(1'b0, 5'd0, '0);
    chk("R3", "zero code err", 256'(swErr), 256'h1);

    // R6 / R7 vector table
    for (int i = 0; i < 4; i++) begin
      logic [4:0] op;
      logic [31:0] seed;
      {op, seed} = VEC[i];
      loadAll(seed);
      chk("R5", "load while idle", 256'(swErr), 256'h0);
      wrCtl(1'b1, op, '0);
      chk("R6", "busy after start", 256'(statusRd), 256'h1);
      chk("R7", "op on port", 256'(accReqOp), 256'(op));
      n = 0;
      while (!statusRd[1] && n < 40) begin tick(); n++; end
      chk("R6", "cycles to ready", 256'(n), 256'd8);
      while (statusRd[0] && n < 60) begin tick(); n++; end
      chk("R7", "cycles to idle", 256'(n), 256'(8 + LAT));
      a0 = mkOpnd(seed); a1 = mkOpnd(seed + 1);
      b0 = mkOpnd(seed + 2); b1 = mkOpnd(seed + 3);
      chk("R7", "result share0", resShare0, expSum(a0, b0, op));
      chk("R7", "result share1", resShare1, expXor(a1, b1, op));
    end

    // R4 / R5 / R9 while running
    loadAll(32'h0BAD_F00D);
    a0 = mkOpnd(32'h0BAD_F00D); a1 = mkOpnd(32'h0BAD_F00E);
    b0 = mkOpnd(32'h0BAD_F00F); b1 = mkOpnd(32'h0BAD_F010);
    wrCtl(1'b1, 5'd23, '0);
    wrOpnd(2'd0, {8{32'hFFFF_FFFF}});
    chk("R5", "write while not ready", 256'(swErr), 256'h1);
    wrCtl(1'b1, 5'd11, '0);
    chk("R4", "start while busy", 256'(swErr), 256'h1);
    chk("R4", "code kept", 256'(ctlRdData), 256'(5'd23 << 1));
    wrCtl(1'b0, 5'd16, '0);
    chk("R4", "config while busy", 256'(swErr), 256'h1);
    n = 0;
    while (!statusRd[1] && n < 40) begin tick(); n++; end
    chk("R9", "busy and ready", 256'(statusRd), 256'h3);
    wrOpnd(2'd0, mkOpnd(32'h1357_9BDF));
    chk("R9", "accepted while busy", 256'(swErr), 256'h0);
    while (statusRd[0] && n < 60) begin tick(); n++; end
    chk("R5", "refused write no effect", resShare0, expSum(a0, b0, 5'd23));
    chk("R4", "op unchanged", resShare1, expXor(a1, b1, 5'd23));

    // R8: hold until first new response
    old0 = resShare0;
    old1 = resShare1;
    a0 = mkOpnd(32'h1357_9BDF);
    e0 = expSum(a0, b0, 5'd12);
    e1 = expXor(a1, b1, 5'd12);
    repeat (2) tick();
    chk("R8", "idle hold", resShare0, old0);
    wrCtl(1'b1, 5'd12, '0);
    repeat (LAT) tick();
    chk("R8", "held before first lane", resShare0, old0);
    chk("R8", "held share1", resShare1, old1);
    tick();
    chk("R8", "lane0 only", resShare0, {old0[255:32], e0[31:0]});
    n = 0;
    while (statusRd[0] && n < 40) begin tick(); n++; end
    chk("R7", "new result share0", resShare0, e0);
    chk("R7", "new result share1", resShare1, e1);

    summary();
    $finish;
  end
endmodule